// File: doc/BRIEF.md
# Single-Slot Packet Timestamp Capture Unit

This block records the free-running 64-bit system time at the moment a packet crosses the MAC timestamp point. It covers both directions. A transmit capture happens only for a packet whose descriptor asked for a stamp. A receive capture happens for every received packet while all-packets mode is selected. Each direction has exactly one capture slot. After a capture the slot stays locked until software reads the upper stamp word. Because only one stamp can be outstanding per direction, the stored value always belongs to the one packet that software is waiting on.

Software reaches the block over a simple register bus. The read data path is combinational. Writes, and the side effect of a read, take effect at the clock edge. Each direction has a control register with an enable bit and a read-only valid flag. The receive control register also carries a filter type field and a read-only clock-frequency indicator. Each direction has a pair of read-only stamp words. A one-cycle flag tells the receive descriptor writeback logic that the current packet was stamped. Software places that flag in the descriptor status at bit 8 (value 0x100).

Top module: `ts_capture_unit`

## Requirements
- R1: After reset, all enable and type bits read as 0, both valid flags read as 0, every stamp word reads as 0, and `rx_taken` is 0.
- R2: The transmit control register is at address 0xB614 and stores bit 4 (enable). Bit 0 is the read-only transmit valid flag, and writing it has no effect. All other bits read as 0.
- R3: The receive control register is at address 0xB620. Bits 3:1 (type) and bit 4 (enable) read back exactly as last written. Bit 0 is the read-only receive valid flag. Bit 5 reads the `SYSCLK_IND` parameter (default 1).
- R4: A cycle with `tx_evt`=1, `tx_req`=1, transmit enable set and the transmit slot empty stores `time_now` from that same cycle. The transmit valid flag is set from the next cycle. The stamp reads at 0xB618 (bits 31:0) and 0xB61C (bits 63:32).
- R5: A `tx_evt` with `tx_req`=0 captures nothing.
- R6: A `rx_evt` with receive enable set, type field = 3'b100 (all packets, control write 0x18) and the receive slot empty stores `time_now` of that cycle and sets the receive valid flag. The stamp reads at 0xB624 (low) and 0xB628 (high). `rx_taken` is 1 for exactly the one cycle after that event.
- R7: While a slot is valid, further events of its direction change neither its stamp nor its valid flag, and `rx_taken` stays 0.
- R8: A read of a direction's high stamp word clears that direction's valid flag and re-arms its slot from the next cycle. A read of the low word does not clear it. An event in the same cycle as the clearing read is not captured.
- R9: With the enable bit at 0, or with a receive type other than 3'b100, events capture nothing and the valid flag stays 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| time_now | input | 64 | Current system time |
| tx_evt | input | 1 | Transmit packet at the timestamp point |
| tx_req | input | 1 | Descriptor of the transmit packet requests a stamp |
| rx_evt | input | 1 | Received packet at the timestamp point |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 16 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data (combinational) |
| rx_taken | output | 1 | Receive packet was stamped; one cycle after its event |

## Verification
The bench sends a second event while a slot is locked. A design that overwrote the slot would return the newer time instead of the first one. It reads the low word and then the control register, to catch a design that clears the valid flag on the wrong word. It fires an event after the high word has been read, to catch a slot that never re-arms. Further cases check that writing the valid bit does nothing, that a transmit event without a descriptor request is ignored, and that a receive type other than all-packets is ignored. A broken design would show a set valid flag or a changed stamp in these cases.

// File: rtl/ts_cap_pkg.sv
package ts_cap_pkg;
    localparam logic [15:0] ADR_TX_CTRL = 16'hB614;
    localparam logic [15:0] ADR_TX_LO   = 16'hB618;
    localparam logic [15:0] ADR_TX_HI   = 16'hB61C;
    localparam logic [15:0] ADR_RX_CTRL = 16'hB620;
    localparam logic [15:0] ADR_RX_LO   = 16'hB624;
    localparam logic [15:0] ADR_RX_HI   = 16'hB628;

    localparam int VALID_BIT  = 0;
    localparam int TYPE_LSB   = 1;
    localparam int TYPE_W     = 3;
    localparam int ENABLE_BIT = 4;
    localparam int SYSCLK_BIT = 5;

    localparam logic [TYPE_W-1:0] TYPE_ALL = 3'b100;

    typedef struct packed {
        logic              tx_en;
        logic              rx_en;
        logic [TYPE_W-1:0] rx_type;
    } ctrl_t;
endpackage

// File: rtl/ts_slot.sv
module ts_slot #(
    parameter int TIME_W = 64
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              arm,
    input  logic              evt,
    input  logic [TIME_W-1:0] time_now,
    input  logic              clear,
    output logic              valid,
    output logic [TIME_W-1:0] stamp,
    output logic              taken
);
    typedef struct packed {
        logic              valid;
        logic [TIME_W-1:0] stamp;
        logic              taken;
    } slot_t;

    slot_t st_d, st_q;
    logic  cap;

    always_comb begin
        st_d       = st_q;
        st_d.taken = 1'b0;
        cap        = arm && evt && !st_q.valid;
        if (cap) begin
            st_d.valid = 1'b1;
            st_d.stamp = time_now;
            st_d.taken = 1'b1;
        end else if (clear) begin
            st_d.valid = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign valid = st_q.valid;
    assign stamp = st_q.stamp;
    assign taken = st_q.taken;
endmodule

// File: rtl/ts_regbank.sv
module ts_regbank
    import ts_cap_pkg::*;
#(
    parameter int   ADDR_W     = 16,
    parameter int   DATA_W     = 32,
    parameter bit   SYSCLK_IND = 1'b1,
    localparam int  TIME_W     = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              tx_valid,
    input  logic [TIME_W-1:0] tx_stamp,
    input  logic              rx_valid,
    input  logic [TIME_W-1:0] rx_stamp,
    output logic              tx_en,
    output logic              rx_en,
    output logic [TYPE_W-1:0] rx_type,
    output logic              tx_hi_rd,
    output logic              rx_hi_rd
);
    ctrl_t ctl_d, ctl_q;

    always_comb begin
        ctl_d = ctl_q;
        if (bus_wr && bus_addr == ADDR_W'(ADR_TX_CTRL)) begin
            ctl_d.tx_en = bus_wdata[ENABLE_BIT];
        end
        if (bus_wr && bus_addr == ADDR_W'(ADR_RX_CTRL)) begin
            ctl_d.rx_en   = bus_wdata[ENABLE_BIT];
            ctl_d.rx_type = bus_wdata[TYPE_LSB +: TYPE_W];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) ctl_q <= '0;
        else        ctl_q <= ctl_d;
    end

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            ADDR_W'(ADR_TX_CTRL): begin
                bus_rdata[VALID_BIT]  = tx_valid;
                bus_rdata[ENABLE_BIT] = ctl_q.tx_en;
            end
            ADDR_W'(ADR_RX_CTRL): begin
                bus_rdata[VALID_BIT]                = rx_valid;
                bus_rdata[TYPE_LSB +: TYPE_W]       = ctl_q.rx_type;
                bus_rdata[ENABLE_BIT]               = ctl_q.rx_en;
                bus_rdata[SYSCLK_BIT]               = SYSCLK_IND;
            end
            ADDR_W'(ADR_TX_LO): bus_rdata = tx_stamp[DATA_W-1:0];
            ADDR_W'(ADR_TX_HI): bus_rdata = tx_stamp[TIME_W-1:DATA_W];
            ADDR_W'(ADR_RX_LO): bus_rdata = rx_stamp[DATA_W-1:0];
            ADDR_W'(ADR_RX_HI): bus_rdata = rx_stamp[TIME_W-1:DATA_W];
            default:            bus_rdata = '0;
        endcase
    end

    assign tx_en    = ctl_q.tx_en;
    assign rx_en    = ctl_q.rx_en;
    assign rx_type  = ctl_q.rx_type;
    assign tx_hi_rd = bus_rd && bus_addr == ADDR_W'(ADR_TX_HI);
    assign rx_hi_rd = bus_rd && bus_addr == ADDR_W'(ADR_RX_HI);
endmodule

// File: rtl/ts_capture_unit.sv
module ts_capture_unit
    import ts_cap_pkg::*;
#(
    parameter int  ADDR_W     = 16,
    parameter int  DATA_W     = 32,
    parameter bit  SYSCLK_IND = 1'b1,
    localparam int TIME_W     = 2 * DATA_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [TIME_W-1:0] time_now,
    input  logic              tx_evt,
    input  logic              tx_req,
    input  logic              rx_evt,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              rx_taken
);
    logic              tx_en, rx_en, tx_hi_rd, rx_hi_rd;
    logic [TYPE_W-1:0] rx_type;
    logic              tx_valid, rx_valid, tx_taken;
    logic [TIME_W-1:0] tx_stamp, rx_stamp;
    logic              tx_arm, rx_arm;

    assign tx_arm = tx_en && tx_req;
    assign rx_arm = rx_en && (rx_type == TYPE_ALL);

    ts_regbank #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .SYSCLK_IND(SYSCLK_IND)
    ) u_regs (
        .clk(clk), .rst_n(rst_n),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .tx_valid(tx_valid), .tx_stamp(tx_stamp),
        .rx_valid(rx_valid), .rx_stamp(rx_stamp),
        .tx_en(tx_en), .rx_en(rx_en), .rx_type(rx_type),
        .tx_hi_rd(tx_hi_rd), .rx_hi_rd(rx_hi_rd)
    );

    ts_slot #(.TIME_W(TIME_W)) u_tx_slot (
        .clk(clk), .rst_n(rst_n), .arm(tx_arm), .evt(tx_evt),
        .time_now(time_now), .clear(tx_hi_rd),
        .valid(tx_valid), .stamp(tx_stamp), .taken(tx_taken)
    );

    ts_slot #(.TIME_W(TIME_W)) u_rx_slot (
        .clk(clk), .rst_n(rst_n), .arm(rx_arm), .evt(rx_evt),
        .time_now(time_now), .clear(rx_hi_rd),
        .valid(rx_valid), .stamp(rx_stamp), .taken(rx_taken)
    );
endmodule

// File: rtl/ts_capture_unit_chk.sv
module ts_capture_unit_chk #(
    parameter int TIME_W = 64
) (
    input logic              clk,
    input logic              rst_n,
    input logic [TIME_W-1:0] time_now,
    input logic              tx_evt,
    input logic              tx_req,
    input logic              rx_evt,
    input logic              tx_en,
    input logic              rx_en,
    input logic [2:0]        rx_type,
    input logic              tx_valid,
    input logic              rx_valid,
    input logic [TIME_W-1:0] tx_stamp,
    input logic [TIME_W-1:0] rx_stamp,
    input logic              tx_hi_rd,
    input logic              rx_hi_rd,
    input logic              rx_taken
);
    p_tx_capture_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_evt && tx_req && tx_en && !tx_valid) |=> (tx_valid && tx_stamp == $past(time_now)));

    p_tx_noreq_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!tx_valid && !(tx_evt && tx_req)) |=> !tx_valid);

    p_rx_taken_r6: assert property (@(posedge clk) disable iff (!rst_n)
        rx_taken |-> (rx_valid && $past(rx_evt)));

    p_rx_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !rx_hi_rd) |=> (rx_valid && $stable(rx_stamp) && !rx_taken));

    p_tx_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && !tx_hi_rd) |=> (tx_valid && $stable(tx_stamp)));

    p_hi_clear_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_valid && tx_hi_rd) |=> !tx_valid);

    p_rx_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (!rx_valid && !(rx_en && rx_type == 3'b100)) |=> !rx_valid);
endmodule

bind ts_capture_unit ts_capture_unit_chk #(.TIME_W(TIME_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .time_now(time_now),
    .tx_evt(tx_evt), .tx_req(tx_req), .rx_evt(rx_evt),
    .tx_en(tx_en), .rx_en(rx_en), .rx_type(rx_type),
    .tx_valid(tx_valid), .rx_valid(rx_valid),
    .tx_stamp(tx_stamp), .rx_stamp(rx_stamp),
    .tx_hi_rd(tx_hi_rd), .rx_hi_rd(rx_hi_rd), .rx_taken(rx_taken)
);

// File: tb/ts_capture_unit_tb.sv
module ts_capture_unit_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [63:0] time_now = '0;
    logic        tx_evt = 1'b0, tx_req = 1'b0, rx_evt = 1'b0;
    logic        bus_wr = 1'b0, bus_rd = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_taken;

    int errors = 0;
    int checks = 0;
    logic [31:0] q_exp[$];
    string       q_tag[$];

    always #5 clk = ~clk;

    ts_capture_unit u_dut (
        .clk(clk), .rst_n(rst_n), .time_now(time_now),
        .tx_evt(tx_evt), .tx_req(tx_req), .rx_evt(rx_evt),
        .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .rx_taken(rx_taken)
    );

    // monitor: pops one expected item per read cycle
    initial begin
        forever begin
            @(negedge clk);
            #2;
            if (bus_rd && q_exp.size() > 0) begin
                logic [31:0] e;
                string t;
                e = q_exp.pop_front();
                t = q_tag.pop_front();
                checks++;
                if (bus_rdata !== e) begin
                    errors++;
                    $display("FAIL %s: addr %h actual %h expected %h", t, bus_addr, bus_rdata, e);
                end
            end
        end
    end

    task automatic rd(input logic [15:0] a, input logic [31:0] e, input string t);
        @(negedge clk);
        bus_addr = a; bus_rd = 1'b1;
        q_exp.push_back(e); q_tag.push_back(t);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic wr(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic tx_pulse(input logic [63:0] t, input logic req);
        @(negedge clk);
        time_now = t; tx_evt = 1'b1; tx_req = req;
        @(negedge clk);
        tx_evt = 1'b0; tx_req = 1'b0; time_now = ~t;
    endtask

    task automatic rx_pulse(input logic [63:0] t);
        @(negedge clk);
        time_now = t; rx_evt = 1'b1;
        @(negedge clk);
        rx_evt = 1'b0; time_now = ~t;
    endtask

    task automatic chk_bit(input logic act, input logic e, input string t);
        #1;
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual %b expected %b", t, act, e);
        end
    endtask

    initial begin
        #(200000 * 10);
        errors++;
        checks++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    localparam logic [63:0] TA = 64'h1234_5678_9ABC_DEF0;
    localparam logic [63:0] TB = 64'h0BAD_F00D_0000_0001;
    localparam logic [63:0] TC = 64'hFFFF_0000_AAAA_5555;
    localparam logic [63:0] TD = 64'h0000_0001_0000_0002;
    localparam logic [63:0] TE = 64'h8000_0000_0000_0007;
    localparam logic [63:0] TF = 64'h7777_6666_5555_4444;
    localparam logic [63:0] TG = 64'h0102_0304_0506_0708;

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        chk_bit(rx_taken, 1'b0, "R1 rx_taken");
        rd(16'hB614, 32'h0, "R1 tx ctrl");
        rd(16'hB620, 32'h20, "R1 rx ctrl (R3 sysclk bit5)");
        rd(16'hB618, 32'h0, "R1 tx lo");
        rd(16'hB62C - 16'h4, 32'h0, "R1 rx hi");
        // R2 enable stored, valid bit not writable
        wr(16'hB614, 32'h11);
        rd(16'hB614, 32'h10, "R2 valid ro");
        // R5 no request
        tx_pulse(TA, 1'b0);
        rd(16'hB614, 32'h10, "R5 no req ctrl");
        rd(16'hB618, 32'h0, "R5 no req lo");
        // R4 capture
        tx_pulse(TA, 1'b1);
        rd(16'hB614, 32'h11, "R4 valid set");
        rd(16'hB618, TA[31:0], "R4 lo");
        rd(16'hB614, 32'h11, "R8 lo read keeps valid");
        // R7 locked
        tx_pulse(TB, 1'b1);
        rd(16'hB618, TA[31:0], "R7 tx lo locked");
        rd(16'hB61C, TA[63:32], "R4 hi");
        rd(16'hB614, 32'h10, "R8 hi read clears");
        // R8 re-armed
        tx_pulse(TC, 1'b1);
        rd(16'hB618, TC[31:0], "R8 rearm lo");
        rd(16'hB61C, TC[63:32], "R8 rearm hi");
        // R9 disabled tx
        wr(16'hB614, 32'h0);
        tx_pulse(TD, 1'b1);
        rd(16'hB614, 32'h0, "R9 tx disabled ctrl");
        rd(16'hB618, TC[31:0], "R9 tx disabled lo");
        // R3 readback and R9 wrong type
        wr(16'hB620, 32'h1A);
        rd(16'hB620, 32'h3A, "R3 readback");
        rx_pulse(TE);
        chk_bit(rx_taken, 1'b0, "R9 wrong type taken");
        rd(16'hB620, 32'h3A, "R9 wrong type ctrl");
        // R6 all-packets capture
        wr(16'hB620, 32'h18);
        rd(16'hB620, 32'h38, "R3 readback all");
        rx_pulse(TE);
        chk_bit(rx_taken, 1'b1, "R6 taken pulse");
        @(negedge clk);
        chk_bit(rx_taken, 1'b0, "R6 taken one cycle");
        rd(16'hB620, 32'h39, "R6 rx valid");
        rd(16'hB624, TE[31:0], "R6 rx lo");
        // R7 rx lock
        rx_pulse(TF);
        chk_bit(rx_taken, 1'b0, "R7 locked taken");
        rd(16'hB624, TE[31:0], "R7 rx lo locked");
        rd(16'hB628, TE[63:32], "R6 rx hi");
        rd(16'hB620, 32'h38, "R8 rx cleared");
        rx_pulse(TG);
        chk_bit(rx_taken, 1'b1, "R8 rx rearm taken");
        rd(16'hB624, TG[31:0], "R8 rx rearm lo");
        rd(16'hB628, TG[63:32], "R8 rx rearm hi");
        // R9 rx disabled with type all
        wr(16'hB620, 32'h08);
        rx_pulse(TA);
        chk_bit(rx_taken, 1'b0, "R9 rx disabled taken");
        rd(16'hB620, 32'h28, "R9 rx disabled ctrl");
        repeat (3) @(negedge clk);
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule